// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words. The format is sign, biased exponent (bias 127) and fraction. An operation code on the input selects addition or subtraction. One clock after a request is accepted, the block returns the packed result together with an overflow flag and a zero flag.

Internally it recovers each operand's significand and orders the pair by exponent. It shifts the smaller significand right to align it. Like signs are summed and unlike signs are subtracted. The difference is then renormalized with a leading-one shift. The result is truncated at every step and no rounding is applied. Special operands (exponent 255), NaN payloads and gradual underflow are not handled. Exponent-zero operands take part only through their missing hidden bit.

Top module: `fpAddSub`

## Requirements
- R1: Word layout is sign in bit 31, exponent in bits 30:23, fraction in bits 22:0. The significand is the fraction with a leading 1 prepended when the exponent is nonzero, and with a leading 0 when it is zero.
- R2: opSel 3'b000 adds and 3'b001 subtracts, by inverting the sign of opB. Any other code is ignored: outValid stays low and the previous result and flags are held.
- R3: A request with a valid code produces outValid high with its result on the clock after it is sampled. Without a request, outValid is low and the outputs do not change. Reset clears every output.
- R4: The operand with the smaller exponent is shifted right by the exponent difference and the bits shifted out are lost. A difference of 24 or more makes it contribute nothing.
- R5: For like effective signs, the significands are summed. On a carry out, the exponent rises by one and the sum is shifted right by one. The result takes the common sign.
- R6: If the exponent reaches 255 through that carry, the result is an infinity of the common sign (exponent 255, fraction 0) and overflow is 1. Otherwise overflow is 0.
- R7: For unlike effective signs, the magnitude difference is shifted left until its top bit is 1. The exponent is lowered by the shift count and the sign is that of the larger magnitude. At equal exponents, the larger significand counts as the larger magnitude.
- R8: An exact cancellation gives +0 (word 32'h0000_0000) with the zero flag set.
- R9: If renormalization would take the exponent below 1, the result is flushed to +0 with the zero flag set.
- R10: No rounding is done. The fraction is the 23 bits below the leading one, and lower bits are discarded. The zero flag is 1 exactly when bits 30:0 of the result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 3 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | Result valid |
| result | output | 32 | Packed result |
| overflow | output | 1 | Exponent overflow to infinity |
| zeroOut | output | 1 | Result magnitude is zero |

## Verification
The bench targets the following corner cases and the wrong results a faulty design would show:
- Exact cancellation: a design that loops or gets the sign wrong returns -0 or garbage instead of +0.
- Operand swap with a negative larger value: a faulty swap takes the wrong sign or subtracts in the wrong direction.
- Carry into exponent 255: a faulty design wraps to a small exponent instead of returning infinity.
- Alignment distances of 23, 24 and beyond: a faulty design wraps the shift and adds stray bits.
- Exponent-zero operands: a design that sets the hidden bit for them gives a visibly larger sum.
- Renormalization below exponent 1: a faulty design underflows the exponent instead of flushing to zero.
- Unsupported operation codes: a faulty design produces a result where none is expected.

// File: rtl/fpAsPkg.sv
package fpAsPkg;
  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;

  typedef struct packed {
    logic fire;
    logic negB;
  } fpAsStrobe_t;
endpackage

// File: rtl/fpAsCtrl.sv
module fpAsCtrl
  import fpAsPkg::*;
(
  input  logic        inValid,
  input  logic [2:0]  opSel,
  output fpAsStrobe_t strobes
);
  always_comb begin
    strobes.fire = inValid && ((opSel == OP_ADD) || (opSel == OP_SUB));
    strobes.negB = (opSel == OP_SUB);
  end
endmodule

// File: rtl/fpAsNorm.sv
module fpAsNorm #(
  parameter int SIG_W = 24,
  parameter int SHW   = $clog2(SIG_W + 1)
) (
  input  logic [SIG_W-1:0] inMag,
  output logic [SHW-1:0]   lzCount,
  output logic [SIG_W-1:0] normSig,
  output logic             isZero
);
  always_comb begin
    lzCount = SHW'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (inMag[i]) lzCount = SHW'(SIG_W - 1 - i);
    end
    normSig = inMag << lzCount;
    isZero  = (inMag == '0);
  end
endmodule

// File: rtl/fpAsDatapath.sv
module fpAsDatapath #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              negB,
  output logic [WORD_W-1:0] nextResult,
  output logic              nextOvf,
  output logic              nextZero
);
  localparam int SHW = $clog2(SIG_W + 1);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic             signA, signB, signL, signS;
  logic [EXP_W-1:0] expA, expB, expL, expS, expDiff;
  logic [SIG_W-1:0] sigA, sigB, sigL, sigS, alignedS;
  logic             swapOps, effSub, carryOut;
  logic [SIG_W:0]   rawSum;
  logic [SIG_W-1:0] subMag, normSig;
  logic [SHW-1:0]   lzCount;
  logic             magZero;
  logic [EXP_W-1:0] expInc;

  always_comb begin
    signA = opA[WORD_W-1];
    expA  = opA[WORD_W-2 -: EXP_W];
    sigA  = {(expA != '0), opA[FRAC_W-1:0]};
    signB = opB[WORD_W-1] ^ negB;
    expB  = opB[WORD_W-2 -: EXP_W];
    sigB  = {(expB != '0), opB[FRAC_W-1:0]};

    swapOps = (expB > expA);
    signL = swapOps ? signB : signA;
    expL  = swapOps ? expB  : expA;
    sigL  = swapOps ? sigB  : sigA;
    signS = swapOps ? signA : signB;
    expS  = swapOps ? expA  : expB;
    sigS  = swapOps ? sigA  : sigB;

    expDiff  = expL - expS;
    alignedS = (32'(expDiff) >= SIG_W) ? '0 : (sigS >> expDiff);

    effSub   = signL ^ signS;
    if (effSub) rawSum = {1'b0, sigL} + {1'b0, ~alignedS} + (SIG_W+1)'(1);
    else        rawSum = {1'b0, sigL} + {1'b0, alignedS};
    carryOut = rawSum[SIG_W];
    subMag   = carryOut ? rawSum[SIG_W-1:0] : (~rawSum[SIG_W-1:0] + SIG_W'(1));
  end

  fpAsNorm #(.SIG_W(SIG_W), .SHW(SHW)) uNorm (
    .inMag  (subMag),
    .lzCount(lzCount),
    .normSig(normSig),
    .isZero (magZero)
  );

  always_comb begin
    expInc     = expL + EXP_W'(1);
    nextOvf    = 1'b0;
    nextResult = '0;
    if (!effSub) begin
      if (carryOut && (expInc == EXP_MAX)) begin
        nextOvf    = 1'b1;
        nextResult = {signL, EXP_MAX, {FRAC_W{1'b0}}};
      end else if (carryOut) begin
        nextResult = {signL, expInc, rawSum[SIG_W-1:1]};
      end else begin
        nextResult = {signL, expL, rawSum[FRAC_W-1:0]};
      end
    end else if (magZero || (EXP_W'(lzCount) >= expL)) begin
      nextResult = '0;
    end else begin
      nextResult = {(carryOut ? signL : signS), expL - EXP_W'(lzCount), normSig[FRAC_W-1:0]};
    end
    nextZero = (nextResult[WORD_W-2:0] == '0);
  end

  always_comb begin
    if (effSub && !magZero) a_r7_norm_msb: assert (normSig[SIG_W-1]);
    if (effSub && (sigL == alignedS)) a_r8_cancel_pos: assert (nextResult == '0);
  end
endmodule

// File: rtl/fpAddSub.sv
module fpAddSub #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              overflow,
  output logic              zeroOut
);
  fpAsPkg::fpAsStrobe_t strobes;
  logic [WORD_W-1:0] nextResult;
  logic              nextOvf, nextZero;

  fpAsCtrl uCtrl (
    .inValid(inValid),
    .opSel  (opSel),
    .strobes(strobes)
  );

  fpAsDatapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uDp (
    .opA       (opA),
    .opB       (opB),
    .negB      (strobes.negB),
    .nextResult(nextResult),
    .nextOvf   (nextOvf),
    .nextZero  (nextZero)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
      zeroOut  <= 1'b0;
    end else begin
      outValid <= strobes.fire;
      if (strobes.fire) begin
        result   <= nextResult;
        overflow <= nextOvf;
        zeroOut  <= nextZero;
      end
    end
  end

  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (result[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) && (result[FRAC_W-1:0] == '0));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result) && $stable(overflow));
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid);
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    zeroOut |-> (result[WORD_W-2:0] == '0));
endmodule

// File: tb/fpAddSub_test.sv
`timescale 1ns/1ps
module fpAddSub_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = 3'b000;
  logic [31:0] opA = '0, opB = '0;
  logic        outValid, overflow, zeroOut;
  logic [31:0] result;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic        pValid = 0, pOvf = 0, pZero = 0;
  logic [31:0] pRes = '0;
  string       pTag = "R3";

  always #10 clk = ~clk;

  fpAddSub uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .overflow(overflow), .zeroOut(zeroOut)
  );

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                       output logic [31:0] r, output logic ovf, output string tag);
    int eA, eB, eL, eS, d, e;
    longint mA, mB, mL, mS, s, diff;
    bit sA, sB, sL, sS, sg;
    sA = a[31]; eA = int'(a[30:23]);
    mA = (eA != 0) ? (longint'(a[22:0]) + 64'h80_0000) : longint'(a[22:0]);
    sB = b[31] ^ (op == 3'b001); eB = int'(b[30:23]);
    mB = (eB != 0) ? (longint'(b[22:0]) + 64'h80_0000) : longint'(b[22:0]);
    if (eB > eA) begin sL = sB; eL = eB; mL = mB; sS = sA; eS = eA; mS = mA; end
    else         begin sL = sA; eL = eA; mL = mA; sS = sB; eS = eB; mS = mB; end
    d = eL - eS;
    mS = (d >= 24) ? 0 : (mS >> d);
    ovf = 0;
    if (sL == sS) begin
      s = mL + mS; e = eL;
      if (s >= 64'h100_0000) begin s = s / 2; e = e + 1; end
      if (e >= 255) begin r = {sL, 8'hFF, 23'h0}; ovf = 1; tag = "R6"; end
      else begin r = {sL, 8'(e), 23'(s)}; tag = "R5"; end
    end else begin
      diff = mL - mS; sg = sL;
      if (diff < 0) begin diff = -diff; sg = sS; end
      if (diff == 0) begin r = '0; tag = "R8"; end
      else begin
        e = eL;
        while (diff < 64'h80_0000) begin diff = diff * 2; e = e - 1; end
        if (e < 1) begin r = '0; tag = "R9"; end
        else begin r = {sg, 8'(e), 23'(diff)}; tag = "R7"; end
      end
    end
  endtask

  task automatic checkOut();
    checks++;
    if (outValid !== pValid || result !== pRes || overflow !== pOvf || zeroOut !== pZero) begin
      errors++;
      $display("FAIL %s: got v=%0b r=%08h o=%0b z=%0b expected v=%0b r=%08h o=%0b z=%0b",
               pTag, outValid, result, overflow, zeroOut, pValid, pRes, pOvf, pZero);
    end
  endtask

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                      input logic vld, input string tagOvr);
    logic [31:0] r; logic o; string t;
    @(negedge clk);
    checkOut();
    opA = a; opB = b; opSel = op; inValid = vld;
    if (vld && (op == 3'b000 || op == 3'b001)) begin
      model(a, b, op, r, o, t);
      pValid = 1; pRes = r; pOvf = o; pZero = (r[30:0] == 0);
      pTag = (tagOvr != "") ? tagOvr : t;
    end else begin
      pValid = 0;
      pTag = vld ? "R2" : "R3";
    end
  endtask

  function automatic logic [31:0] randOp();
    logic [31:0] w;
    w = $urandom;
    if ($urandom % 10 == 0) w[30:0] = '0;
    else w[30:23] = 8'(1 + $urandom % 254);
    return w;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 0 || result !== 0 || overflow !== 0 || zeroOut !== 0) begin
      errors++;
      $display("FAIL R3 reset: got v=%0b r=%08h expected v=0 r=00000000", outValid, result);
    end
    rstN = 1'b1;
    step(32'h3F80_0000, 32'h3F80_0000, 3'b000, 1, "R5");   // 1+1 = 2
    step(32'h3FC0_0000, 32'h3F80_0000, 3'b001, 1, "R7");   // 1.5-1 = 0.5
    step(32'h3F80_0000, 32'h3F80_0000, 3'b001, 1, "R8");   // exact cancel
    step(32'h3F80_0000, 32'hC000_0000, 3'b000, 1, "R7");   // swap, negative larger
    step(32'h7F40_0000, 32'h7F40_0000, 3'b000, 1, "R6");   // overflow
    step(32'h3F80_0000, 32'h3380_0000, 3'b000, 1, "R4");   // d = 24
    step(32'h3F80_0000, 32'h3400_0000, 3'b000, 1, "R4");   // d = 23
    step(32'h3F80_0000, 32'h3440_0000, 3'b000, 1, "R10");  // truncation
    step(32'h0080_0000, 32'h0040_0000, 3'b000, 1, "R1");   // hidden bit 0
    step(32'h0080_0001, 32'h0080_0000, 3'b001, 1, "R9");   // flush
    step(32'h4000_0000, 32'h3F80_0000, 3'b010, 1, "R2");   // ignored code
    step(32'h4000_0000, 32'h3F80_0000, 3'b111, 1, "R2");
    step(32'h4000_0000, 32'h3F80_0000, 3'b001, 0, "R3");   // idle
    step(32'h8000_0000, 32'h8000_0000, 3'b000, 1, "R10");  // -0 + -0
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b;
      a = randOp(); b = randOp();
      if (($urandom % 3) == 0 && a[30:23] != 0) b[30:23] = a[30:23] - 8'($urandom % 3);
      if (b[30:23] == 8'hFF) b[30:23] = 8'hFE;
      step(a, b, 3'($urandom % 9 < 8 ? $urandom % 2 : 2 + $urandom % 6),
           ($urandom % 8) != 0, "");
    end
    step('0, '0, 3'b000, 0, "R3");
    @(negedge clk);
    checkOut();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule